// File: doc/BRIEF.md
# Block Address Translation Matcher

This unit translates a 32-bit effective address through a small table of block translation entries, without walking a page table. Each entry is a pair of 32-bit words: an upper word holding the effective block index, a length mask and two privilege enables, and a lower word holding the physical block number and a protection code. Instruction fetches are translated through one bank of entries. Data reads and writes go through a second bank.

A request strobe presents an address, an access kind and a privilege bit. The unit searches the selected bank and picks the lowest-numbered entry that both matches the address and is enabled for the current privilege. From that entry it builds the physical address and the grant set, then checks the grant set against the access kind. One cycle later it reports one of three outcomes: granted, protection fault, or miss.

A write port loads the table one word at a time. The length field lets a single entry cover a block of 128 KiB up to 256 MiB. It does this by taking the masked effective-address bits out of the compare and passing them into the physical address.

Top module: `bat_xlate`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` on the clock edge. `wr_instr` selects the bank (1 = instruction, 0 = data), `wr_upper` selects the word (1 = upper, 0 = lower) and `wr_idx` selects the entry. The new value is used by every request presented after that edge.
- R2: Upper-word layout: block index in bits 31:17, length mask in bits 12:2, supervisor enable in bit 1, user enable in bit 0. Effective-address bits 31:28 must equal index bits 31:28 exactly for a match.
- R3: Length bit k+2 masks effective-address bit k+17, for k = 0..10. Effective-address bits 27:17 are ANDed with the inverted mask and then compared with index bits 27:17, so a set mask bit removes its address bit from the compare.
- R4: An address-matching entry counts only if `req_user`=0 and its supervisor enable is set, or if `req_user`=1 and its user enable is set. A matching entry that is not enabled is skipped, and the search continues.
- R5: When several entries qualify, the lowest-numbered one decides the result.
- R6: A fetch (`req_kind`=0) searches only the instruction bank. A read (`req_kind`=1 or 3) or a write (`req_kind`=2) searches only the data bank.
- R7: Lower-word layout: physical block number in bits 31:17, protection code in bits 1:0. Code 0 grants nothing. Code 2 grants read, write and execute. Codes 1 and 3 grant read and execute.
- R8: On a hit, a fetch needs execute, a write needs write and a read needs read. `result` is 1 when the check passes, 2 when it fails, and 0 on a miss.
- R9: On a hit, `pa[31:28]` is physical bits 31:28. `pa[27:17]` is (address bits under the length mask) OR physical bits 27:17. `pa[16:0]` is effective-address bits 16:0.
- R10: `done` pulses for exactly the one cycle after a cycle with `req` high, and the outputs update at that edge. A miss drives `pa` and all grant outputs to zero. The outputs hold their values until the next request.
- R11: Reset clears every table word. It also clears `done`, `pa` and the grant outputs and sets `result` to miss, so any request after reset misses until the table is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_instr | input | 1 | 1 = instruction bank, 0 = data bank |
| wr_upper | input | 1 | 1 = upper word, 0 = lower word |
| wr_idx | input | 2 | Entry number |
| wr_data | input | 32 | Word to store |
| req | input | 1 | Translation request strobe |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_user | input | 1 | Privilege: 1 = user, 0 = supervisor |
| done | output | 1 | Result valid pulse |
| result | output | 2 | 0 miss, 1 granted, 2 protection fault |
| pa | output | 32 | Physical address |
| perm_r | output | 1 | Read granted by the hit entry |
| perm_w | output | 1 | Write granted by the hit entry |
| perm_x | output | 1 | Execute granted by the hit entry |

## Verification
There is exactly one register between the request inputs and every output. `done`, `result`, `pa` and the grant bits are therefore due at the first rising edge after the cycle in which `req` is high. The bench drives a request on a falling edge and drops the strobe on the next falling edge. It then compares the outputs there, half a cycle after they update. Table writes use the same half-cycle spacing, so every request sees the word written on the preceding edge. After a result the bench waits one more falling edge to confirm that `done` has dropped while the other outputs hold.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_READ2 = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        RES_MISS  = 2'd0,
        RES_GRANT = 2'd1,
        RES_FAULT = 2'd2
    } result_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    typedef struct packed {
        logic [WORD_W-1:0] pa;
        perm_t             perm;
    } xlate_t;

    // Grant set implied by a two-bit protection code.
    function automatic perm_t prot_decode(input logic [1:0] code);
        perm_t p;
        p.r = (code != 2'd0);
        p.x = (code != 2'd0);
        p.w = (code == 2'd2);
        return p;
    endfunction

    // Does the grant set allow the requested kind of access?
    function automatic logic perm_allows(input perm_t p, input kind_e k);
        logic ok;
        case (k)
            KIND_FETCH: ok = p.x;
            KIND_WRITE: ok = p.w;
            default:    ok = p.r;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bat_bank.sv
module bat_bank #(
    parameter int unsigned ENTRIES = 4,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic                         wr_upper,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [31:0]                  wr_data,
    output logic [ENTRIES-1:0][31:0]     upper_q,
    output logic [ENTRIES-1:0][31:0]     lower_q
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                upper_q[i] <= '0;
                lower_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                if (wr_upper) upper_q[i] <= wr_data;
                else          lower_q[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/bat_entry_eval.sv
module bat_entry_eval
    import bat_pkg::*;
(
    input  logic [31:0] upper,
    input  logic [31:0] lower,
    input  logic [31:0] ea,
    input  logic        user,
    output logic        hit,
    output xlate_t      xl
);
    logic [10:0] len_mask;
    logic        addr_match;
    logic        enabled;

    always_comb begin
        len_mask   = upper[12:2];
        addr_match = (ea[31:28] == upper[31:28]) &&
                     ((ea[27:17] & ~len_mask) == upper[27:17]);
        enabled    = user ? upper[0] : upper[1];
        hit        = addr_match && enabled;
        xl.pa      = {lower[31:28], (ea[27:17] & len_mask) | lower[27:17], ea[16:0]};
        xl.perm    = prot_decode(lower[1:0]);
    end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
    import bat_pkg::*;
#(
    parameter int unsigned ENTRIES = 4,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_instr,
    input  logic             wr_upper,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             req,
    input  logic [31:0]      req_ea,
    input  logic [1:0]       req_kind,
    input  logic             req_user,
    output logic             done,
    output logic [1:0]       result,
    output logic [31:0]      pa,
    output logic             perm_r,
    output logic             perm_w,
    output logic             perm_x
);
    localparam int unsigned BANKS = 2; // 0 data, 1 instruction

    logic [BANKS-1:0][ENTRIES-1:0][31:0] up_q;
    logic [BANKS-1:0][ENTRIES-1:0][31:0] lo_q;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bat_bank #(.ENTRIES(ENTRIES)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en && (wr_instr == (b == 1))),
            .wr_upper (wr_upper),
            .wr_idx   (wr_idx),
            .wr_data  (wr_data),
            .upper_q  (up_q[b]),
            .lower_q  (lo_q[b])
        );
    end

    kind_e kind;
    logic  use_instr;
    assign kind      = kind_e'(req_kind);
    assign use_instr = (kind == KIND_FETCH);

    logic   [ENTRIES-1:0] ent_hit;
    xlate_t               ent_xl [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_eval
        bat_entry_eval u_eval (
            .upper (use_instr ? up_q[1][i] : up_q[0][i]),
            .lower (use_instr ? lo_q[1][i] : lo_q[0][i]),
            .ea    (req_ea),
            .user  (req_user),
            .hit   (ent_hit[i]),
            .xl    (ent_xl[i])
        );
    end

    // Lowest-numbered qualifying entry wins.
    logic    any_hit;
    xlate_t  win_xl;
    result_e res_d;

    always_comb begin
        any_hit = 1'b0;
        win_xl  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (ent_hit[i]) begin
                any_hit = 1'b1;
                win_xl  = ent_xl[i];
            end
        end
        if (!any_hit)                        res_d = RES_MISS;
        else if (perm_allows(win_xl.perm, kind)) res_d = RES_GRANT;
        else                                 res_d = RES_FAULT;
    end

    xlate_t out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            result <= RES_MISS;
            out_q  <= '0;
        end else begin
            done <= req;
            if (req) begin
                result <= res_d;
                out_q  <= win_xl;
            end
        end
    end

    assign pa     = out_q.pa;
    assign perm_r = out_q.perm.r;
    assign perm_w = out_q.perm.w;
    assign perm_x = out_q.perm.x;
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req,
    input logic [1:0]  req_kind,
    input logic        done,
    input logic [1:0]  result,
    input logic [31:0] pa,
    input logic        perm_r,
    input logic        perm_w,
    input logic        perm_x
);
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req |=> done); // R10
    AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(req)); // R10
    AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (done && result == 2'd0) |-> (pa == 32'd0 && !perm_r && !perm_w && !perm_x)); // R10
    AST_WRITE_MEANS_ALL: assert property (@(posedge clk) disable iff (rst)
        perm_w |-> (perm_r && perm_x)); // R7
    AST_GRANT_FETCH_EXEC: assert property (@(posedge clk) disable iff (rst)
        (done && result == 2'd1 && $past(req_kind) == 2'd0) |-> perm_x); // R8
    AST_GRANT_WRITE_WR: assert property (@(posedge clk) disable iff (rst)
        (done && result == 2'd1 && $past(req_kind) == 2'd2) |-> perm_w); // R8
    AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        result != 2'd3); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(req) && !$past(rst)) |-> ($stable(pa) && $stable(result))); // R10
endmodule

bind bat_xlate bat_xlate_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_kind (req_kind),
    .done     (done),
    .result   (result),
    .pa       (pa),
    .perm_r   (perm_r),
    .perm_w   (perm_w),
    .perm_x   (perm_x)
);

// File: tb/bat_xlate_test.sv
module bat_xlate_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_instr, wr_upper;
    logic [1:0]  wr_idx;
    logic [31:0] wr_data;
    logic        req;
    logic [31:0] req_ea;
    logic [1:0]  req_kind;
    logic        req_user;
    logic        done;
    logic [1:0]  result;
    logic [31:0] pa;
    logic        perm_r, perm_w, perm_x;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk; // 125 MHz

    bat_xlate uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_instr(wr_instr),
        .wr_upper(wr_upper), .wr_idx(wr_idx), .wr_data(wr_data),
        .req(req), .req_ea(req_ea), .req_kind(req_kind), .req_user(req_user),
        .done(done), .result(result), .pa(pa),
        .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic write_word(input bit instr, input bit upper, input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_instr = instr; wr_upper = upper; wr_idx = 2'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic load(input bit instr, input int idx, input logic [31:0] up, input logic [31:0] lo);
        write_word(instr, 1, idx, up);
        write_word(instr, 0, idx, lo);
    endtask

    // Present a request, then check outputs one edge later.
    task automatic lookup(input string tag, input logic [31:0] ea, input logic [1:0] kind,
                          input bit user, input logic [1:0] exp_res,
                          input logic [31:0] exp_pa, input logic [2:0] exp_rwx);
        @(negedge clk);
        req = 1; req_ea = ea; req_kind = kind; req_user = user;
        @(negedge clk);
        req = 0;
        check({tag, " done"}, 32'(done), 32'd1);
        check({tag, " result"}, 32'(result), 32'(exp_res));
        check({tag, " pa"}, pa, exp_pa);
        check({tag, " rwx"}, 32'({perm_r, perm_w, perm_x}), 32'(exp_rwx));
    endtask

    task automatic t_reset;
        check("R11 done after reset", 32'(done), 32'd0);
        check("R11 result after reset", 32'(result), 32'd0);
        check("R11 pa after reset", pa, 32'd0);
        lookup("R11 empty table", 32'h1000_0000, 2'd1, 0, 2'd0, 32'd0, 3'b000);
    endtask

    task automatic t_basic;
        load(0, 0, 32'h1000_0002, 32'h8000_0002);
        lookup("R9 basic read", 32'h1001_2345, 2'd1, 0, 2'd1, 32'h8001_2345, 3'b111);
        lookup("R8 write on code2", 32'h1000_0000, 2'd2, 0, 2'd1, 32'h8000_0000, 3'b111);
        lookup("R2 top bits differ", 32'h9001_2345, 2'd1, 0, 2'd0, 32'd0, 3'b000);
    endtask

    task automatic t_hold;
        @(negedge clk);
        check("R10 done drops", 32'(done), 32'd0);
        check("R10 result holds", 32'(result), 32'd0);
    endtask

    task automatic t_length;
        load(0, 1, 32'h2000_1FFF, 32'h4000_0001);
        lookup("R8 write on code1 faults", 32'h2ABC_DEF0, 2'd2, 0, 2'd2, 32'h4ABC_DEF0, 3'b101);
        lookup("R3 full mask read", 32'h2ABC_DEF0, 2'd1, 1, 2'd1, 32'h4ABC_DEF0, 3'b101);
        load(0, 2, 32'h3020_001E, 32'h5010_0003);
        lookup("R3 partial mask", 32'h302E_1234, 2'd3, 0, 2'd1, 32'h501E_1234, 3'b101);
        lookup("R3 unmasked bit differs", 32'h3060_0000, 2'd1, 0, 2'd0, 32'd0, 3'b000);
    endtask

    task automatic t_privilege;
        lookup("R4 user not enabled", 32'h1001_2345, 2'd1, 1, 2'd0, 32'd0, 3'b000);
    endtask

    task automatic t_banks;
        load(1, 0, 32'h1000_0003, 32'h9000_0002);
        lookup("R6 fetch uses instr bank", 32'h1000_0100, 2'd0, 0, 2'd1, 32'h9000_0100, 3'b111);
        lookup("R6 read uses data bank", 32'h1000_0100, 2'd1, 0, 2'd1, 32'h8000_0100, 3'b111);
        lookup("R6 fetch ignores data bank", 32'h2ABC_0000, 2'd0, 0, 2'd0, 32'd0, 3'b000);
    endtask

    task automatic t_priority;
        load(0, 3, 32'h1000_0003, 32'hA000_0002);
        lookup("R5 lowest wins", 32'h1000_0000, 2'd1, 0, 2'd1, 32'h8000_0000, 3'b111);
        lookup("R4 skip to next entry", 32'h1000_0000, 2'd1, 1, 2'd1, 32'hA000_0000, 3'b111);
    endtask

    task automatic t_prot;
        load(1, 1, 32'h7000_0002, 32'h7000_0000);
        lookup("R7 code0 fetch faults", 32'h7000_0000, 2'd0, 0, 2'd2, 32'h7000_0000, 3'b000);
        load(1, 2, 32'h6000_0002, 32'h6000_0001);
        lookup("R8 fetch on code1 granted", 32'h6000_0040, 2'd0, 0, 2'd1, 32'h6000_0040, 3'b101);
    endtask

    task automatic t_rewrite;
        write_word(0, 1, 1, 32'h0);
        lookup("R1 rewritten entry misses", 32'h2ABC_DEF0, 2'd1, 0, 2'd0, 32'd0, 3'b000);
    endtask

    task automatic t_mid_reset;
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        lookup("R11 table cleared", 32'h1000_0000, 2'd1, 0, 2'd0, 32'd0, 3'b000);
    endtask

    initial begin
        #(8 * 5000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1; wr_en = 0; wr_instr = 0; wr_upper = 0; wr_idx = 0; wr_data = 0;
        req = 0; req_ea = 0; req_kind = 0; req_user = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset;
        t_basic;
        t_hold;
        t_length;
        t_privilege;
        t_banks;
        t_priority;
        t_prot;
        t_rewrite;
        t_mid_reset;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule